// File: doc/BRIEF.md
# Calibrated Seconds Timer

This block keeps wall-clock time as an unsigned count of seconds. A slow oscillator supplies a one-cycle tick enable. A prescaler counts those ticks. When it reaches a programmed limit it closes the current second and the seconds counter advances. A fractional trim stretches selected seconds by one tick, so the average period can match an oscillator whose rate is not a whole number of ticks per second. Calendar conversion is left to software.

Software reaches the block through a flat 32-bit register port. Writes are single-cycle and reads are combinational. Through this port software can:
- load the time;
- read the running count and the position within the current second;
- program the prescaler and an alarm value;
- handle two interrupt sources.

The two sources are a per-second event (bit 0) and an alarm match (bit 1). Each has a pending bit that software clears by writing 1. Each also has a mask bit, changed only through separate write-only set and clear registers. Each source drives its own interrupt line.

Register offsets, with only the low 6 address bits decoded and all upper address bits required to be zero:

| Offset | Access | Meaning |
|---|---|---|
| 0x00 | read/write | control: bit 0 = run |
| 0x04 | write / read | time load; reads return the last value loaded |
| 0x08 | read | current seconds |
| 0x0C | read | prescaler position within the current second |
| 0x10 | read/write | calibration |
| 0x14 | read/write | alarm value |
| 0x18 | read / write 1 to clear | pending bits |
| 0x1C | read | mask bits (1 = masked) |
| 0x20 | write | unmask (1 = unmask that source) |
| 0x24 | write | mask (1 = mask that source) |

Top module: `rtc_core`

## Requirements
- R1: After reset the seconds count, the prescaler position, the pending bits and the run bit (offset 0x00 bit 0) read 0. Both mask bits (offset 0x1C bits 1:0) read 1. The calibration register (offset 0x10) reads the CAL_RESET parameter, whose default is 0x198233. Both interrupt lines are low.
- R2: The prescaler and the seconds counter hold their values when either the run bit is 0 or the oscillator tick enable is low.
- R3: Calibration bits 15:0 hold a value P, and each second lasts P+1 ticks. The position register at offset 0x0C counts 0 to P and returns to 0 on the tick that advances the seconds counter.
- R4: Calibration bit 20 enables fractional trim and bits 19:16 hold an amount F. The prescaler keeps a 16-second window count, which restarts on a time load. With trim enabled, the first F seconds of each window last P+2 ticks and the rest last P+1.
- R5: A write to offset 0x04 loads the seconds counter and restarts the prescaler position and the window count at 0. A later read of 0x04 returns the value written.
- R6: The seconds counter wraps from 0xFFFFFFFF to 0, and that step sets pending bit 0.
- R7: Every advance of the seconds counter caused by the prescaler sets pending bit 0.
- R8: Pending bit 1 is set when a prescaler advance makes the seconds count equal to the alarm register (offset 0x14). A time load that writes the alarm value does not set it.
- R9: Writing 1 to a bit of offset 0x18 clears that pending bit, and writing 0 leaves it unchanged. If a new event and a clear reach the same bit in the same cycle, the bit stays set.
- R10: Writing 1 to a bit of offset 0x20 clears that mask bit, and writing 1 to offset 0x24 sets it. Zero bits written to either register leave the mask unchanged.
- R11: irq_second is high exactly when pending bit 0 is set and unmasked. irq_alarm is high exactly when pending bit 1 is set and unmasked.
- R12: Offsets outside the map, or addresses with nonzero upper bits, read as 0. Writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_tick | input | 1 | One-cycle enable per oscillator tick |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | ADDR_W (8) | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| irq_second | output | 1 | Per-second interrupt |
| irq_alarm | output | 1 | Alarm interrupt |

## Verification
The bench keeps the default widths: 16-bit ticks, 4-bit trim and a 32-bit second count. It loads the calibration at run time with very small tick counts, from 0 to 5, which makes a whole second last only a few cycles. With periods that short, the bench can compare every tick against an arithmetic model. This covers several plain periods and all sixteen trim amounts across complete 16-second windows. Loading the time near 0xFFFFFFFF brings the counter wrap and alarm matches within a few ticks.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   typedef logic [5:0] reg_off_t;

   localparam reg_off_t OFF_CTRL     = 6'h00;
   localparam reg_off_t OFF_LOAD     = 6'h04;
   localparam reg_off_t OFF_NOW      = 6'h08;
   localparam reg_off_t OFF_POS      = 6'h0C;
   localparam reg_off_t OFF_CALIB    = 6'h10;
   localparam reg_off_t OFF_ALARM    = 6'h14;
   localparam reg_off_t OFF_PENDING  = 6'h18;
   localparam reg_off_t OFF_MASK     = 6'h1C;
   localparam reg_off_t OFF_UNMASK   = 6'h20;
   localparam reg_off_t OFF_SETMASK  = 6'h24;

   localparam int N_IRQ   = 2;
   localparam int IRQ_SEC = 0;
   localparam int IRQ_ALM = 1;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
   parameter int TICK_W  = 16,
   parameter int FRAC_W  = 4,
   parameter bit FRAC_HW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic              restart,
   input  logic [TICK_W-1:0] last_tick,
   input  logic [FRAC_W-1:0] frac_amt,
   input  logic              frac_on,
   output logic [TICK_W-1:0] pos,
   output logic              sec_end
);
   localparam int CNT_W = TICK_W + 1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit;
   logic             stretch;

   if (TICK_W < 2)  begin : g_chk_tick
      $error("rtc_prescaler: TICK_W too small");
   end
   if (FRAC_W < 1)  begin : g_chk_frac
      $error("rtc_prescaler: FRAC_W must be at least 1");
   end

   generate
      if (FRAC_HW) begin : g_frac
         logic [FRAC_W-1:0] phase_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       phase_q <= '0;
            else if (restart) phase_q <= '0;
            else if (sec_end) phase_q <= phase_q + 1'b1;
         end
         assign stretch = frac_on && (phase_q < frac_amt);
      end else begin : g_nofrac
         assign stretch = 1'b0;
      end
   endgenerate

   assign limit   = {1'b0, last_tick} + CNT_W'(stretch);
   assign sec_end = step && (cnt_q >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (restart) cnt_q <= '0;
      else if (sec_end) cnt_q <= '0;
      else if (step)    cnt_q <= cnt_q + 1'b1;
   end

   assign pos = cnt_q[TICK_W-1:0];

   assert_count_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
      step && !restart && !sec_end |=> cnt_q == $past(cnt_q) + 1'b1);
   assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sec_end |=> cnt_q == '0);
   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !step && !restart |=> $stable(cnt_q));
endmodule

// File: rtl/rtc_seconds.sv
module rtc_seconds #(
   parameter int SEC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [SEC_W-1:0] load_val,
   input  logic             advance,
   input  logic [SEC_W-1:0] alarm_val,
   output logic [SEC_W-1:0] secs,
   output logic             tick_evt,
   output logic             alarm_evt
);
   logic [SEC_W-1:0] secs_q;
   logic [SEC_W-1:0] secs_nxt;

   if (SEC_W < 8 || SEC_W > 32) begin : g_chk_sec
      $error("rtc_seconds: SEC_W out of range");
   end

   assign secs_nxt  = secs_q + 1'b1;
   assign tick_evt  = advance && !load;
   assign alarm_evt = tick_evt && (secs_nxt == alarm_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       secs_q <= '0;
      else if (load)    secs_q <= load_val;
      else if (advance) secs_q <= secs_nxt;
   end

   assign secs = secs_q;

   assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> secs_q == $past(load_val));
   assert_advance_wraps_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tick_evt && (secs_q == '1) |=> secs_q == '0);
   assert_alarm_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_evt |=> secs_q == $past(alarm_val));
endmodule

// File: rtl/rtc_irq.sv
module rtc_irq #(
   parameter int N_SRC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] evt,
   input  logic [N_SRC-1:0] ack,
   input  logic [N_SRC-1:0] unmask_set,
   input  logic [N_SRC-1:0] mask_set,
   output logic [N_SRC-1:0] pending,
   output logic [N_SRC-1:0] masked,
   output logic [N_SRC-1:0] irq
);
   if (N_SRC < 1 || N_SRC > 32) begin : g_chk_src
      $error("rtc_irq: N_SRC out of range");
   end

   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      pending[i] <= 1'b0;
         else if (evt[i]) pending[i] <= 1'b1;
         else if (ack[i]) pending[i] <= 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)             masked[i] <= 1'b1;
         else if (mask_set[i])   masked[i] <= 1'b1;
         else if (unmask_set[i]) masked[i] <= 1'b0;
      end

      assign irq[i] = pending[i] & ~masked[i];

      assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
         evt[i] |=> pending[i]);
      assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
         ack[i] && !evt[i] |=> !pending[i]);
      assert_mask_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
         mask_set[i] |=> masked[i]);
      assert_unmask_R10: assert property (@(posedge clk) disable iff (!rst_n)
         unmask_set[i] && !mask_set[i] |=> !masked[i]);
   end
endmodule

// File: rtl/rtc_core.sv
module rtc_core #(
   parameter int          ADDR_W    = 8,
   parameter int          SEC_W     = 32,
   parameter int          TICK_W    = 16,
   parameter int          FRAC_W    = 4,
   parameter bit          FRAC_HW   = 1'b1,
   parameter logic [31:0] CAL_RESET = 32'h0019_8233
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              osc_tick,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq_second,
   output logic              irq_alarm
);
   import rtc_pkg::*;

   localparam int CAL_W   = TICK_W + FRAC_W + 1;
   localparam int FRAC_LO = TICK_W;
   localparam int FRAC_ON = TICK_W + FRAC_W;

   if (ADDR_W < 7)     begin : g_chk_addr
      $error("rtc_core: ADDR_W must be at least 7");
   end
   if (CAL_W > 32)     begin : g_chk_cal
      $error("rtc_core: calibration does not fit the data path");
   end

   logic             hit;
   reg_off_t         off;
   logic             wr_ctrl, wr_load, wr_calib, wr_alarm;
   logic             wr_pend, wr_unmask, wr_mask;
   logic             run_q;
   logic [SEC_W-1:0] load_q, alarm_q, secs_now;
   logic [CAL_W-1:0] calib_q;
   logic             step, sec_end, tick_evt, alarm_evt;
   logic [TICK_W-1:0] pos;
   logic [N_IRQ-1:0] pending, masked, irq_vec;

   assign off  = bus_addr[5:0];
   assign hit  = ~|bus_addr[ADDR_W-1:6];

   assign wr_ctrl   = bus_we && hit && (off == OFF_CTRL);
   assign wr_load   = bus_we && hit && (off == OFF_LOAD);
   assign wr_calib  = bus_we && hit && (off == OFF_CALIB);
   assign wr_alarm  = bus_we && hit && (off == OFF_ALARM);
   assign wr_pend   = bus_we && hit && (off == OFF_PENDING);
   assign wr_unmask = bus_we && hit && (off == OFF_UNMASK);
   assign wr_mask   = bus_we && hit && (off == OFF_SETMASK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         load_q  <= '0;
         alarm_q <= '0;
         calib_q <= CAL_RESET[CAL_W-1:0];
      end else begin
         if (wr_ctrl)  run_q   <= bus_wdata[0];
         if (wr_load)  load_q  <= bus_wdata[SEC_W-1:0];
         if (wr_alarm) alarm_q <= bus_wdata[SEC_W-1:0];
         if (wr_calib) calib_q <= bus_wdata[CAL_W-1:0];
      end
   end

   assign step = osc_tick && run_q;

   rtc_prescaler #(.TICK_W(TICK_W), .FRAC_W(FRAC_W), .FRAC_HW(FRAC_HW)) u_presc (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (step),
      .restart   (wr_load),
      .last_tick (calib_q[TICK_W-1:0]),
      .frac_amt  (calib_q[FRAC_ON-1:FRAC_LO]),
      .frac_on   (calib_q[FRAC_ON]),
      .pos       (pos),
      .sec_end   (sec_end)
   );

   rtc_seconds #(.SEC_W(SEC_W)) u_secs (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (wr_load),
      .load_val  (bus_wdata[SEC_W-1:0]),
      .advance   (sec_end),
      .alarm_val (alarm_q),
      .secs      (secs_now),
      .tick_evt  (tick_evt),
      .alarm_evt (alarm_evt)
   );

   rtc_irq #(.N_SRC(N_IRQ)) u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt        ({alarm_evt, tick_evt}),
      .ack        (wr_pend   ? bus_wdata[N_IRQ-1:0] : '0),
      .unmask_set (wr_unmask ? bus_wdata[N_IRQ-1:0] : '0),
      .mask_set   (wr_mask   ? bus_wdata[N_IRQ-1:0] : '0),
      .pending    (pending),
      .masked     (masked),
      .irq        (irq_vec)
   );

   assign irq_second = irq_vec[IRQ_SEC];
   assign irq_alarm  = irq_vec[IRQ_ALM];

   always_comb begin
      bus_rdata = '0;
      if (hit) begin
         case (off)
            OFF_CTRL:    bus_rdata = {31'd0, run_q};
            OFF_LOAD:    bus_rdata = 32'(load_q);
            OFF_NOW:     bus_rdata = 32'(secs_now);
            OFF_POS:     bus_rdata = 32'(pos);
            OFF_CALIB:   bus_rdata = 32'(calib_q);
            OFF_ALARM:   bus_rdata = 32'(alarm_q);
            OFF_PENDING: bus_rdata = 32'(pending);
            OFF_MASK:    bus_rdata = 32'(masked);
            default:     bus_rdata = '0;
         endcase
      end
   end

   assert_stopped_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q && !wr_load |=> $stable(secs_now));
   assert_irq_needs_unmask_R11: assert property (@(posedge clk) disable iff (!rst_n)
      irq_second |-> !masked[IRQ_SEC] && pending[IRQ_SEC]);
endmodule

// File: tb/sim_rtc_core.sv
module sim_rtc_core;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        osc_tick = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_second, irq_alarm;

   int n_tests = 0;
   int n_fail  = 0;
   bit finished = 1'b0;

   logic [31:0] exp_sec;
   int          exp_pos, exp_ph, mP, mF;
   bit          mOn;

   always #2.5 clk = ~clk;

   rtc_core u0 (
      .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_second(irq_second), .irq_alarm(irq_alarm)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(posedge clk); @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a; #1; d = bus_rdata;
   endtask

   task automatic tick(input int n);
      osc_tick = 1'b1;
      repeat (n) @(negedge clk);
      osc_tick = 1'b0;
   endtask

   task automatic model_load(input logic [31:0] v);
      exp_sec = v; exp_pos = 0; exp_ph = 0;
   endtask

   task automatic model_tick();
      int len;
      len = mP + 1 + ((mOn && exp_ph < mF) ? 1 : 0);
      if (exp_pos == len - 1) begin
         exp_pos = 0; exp_sec = exp_sec + 1; exp_ph = (exp_ph + 1) % 16;
      end else exp_pos++;
   endtask

   task automatic sweep(input string req, input int nt);
      logic [31:0] d;
      for (int k = 0; k < nt; k++) begin
         tick(1); model_tick();
         rd(8'h0C, d); chk(req, d, 32'(exp_pos));
         rd(8'h08, d); chk(req, d, exp_sec);
      end
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(8'h08, d); chk("R1 secs", d, 0);
      rd(8'h0C, d); chk("R1 pos", d, 0);
      rd(8'h18, d); chk("R1 pending", d, 0);
      rd(8'h1C, d); chk("R1 mask", d, 3);
      rd(8'h10, d); chk("R1 calib", d, 32'h0019_8233);
      rd(8'h00, d); chk("R1 run", d, 0);
      chk("R1 irq", {30'd0, irq_alarm, irq_second}, 0);

      // R2 stopped: ticks ignored
      wr(8'h10, 32'd2);
      tick(10);
      rd(8'h0C, d); chk("R2 pos held", d, 0);
      rd(8'h08, d); chk("R2 secs held", d, 0);

      // R3 plain periods, R5 load restarts
      wr(8'h00, 1);
      for (int p = 0; p <= 5; p++) begin
         mP = p; mF = 0; mOn = 1'b0;
         wr(8'h10, 32'(p));
         wr(8'h04, 32'd100 + p); model_load(32'd100 + p);
         rd(8'h04, d); chk("R5 readback", d, 32'd100 + p);
         rd(8'h0C, d); chk("R5 pos zero", d, 0);
         sweep("R3", 4 * (p + 1) + 2);
      end

      // R2 osc tick enable low holds mid-second
      wr(8'h10, 32'd5); wr(8'h04, 0); model_load(0); mP = 5;
      tick(3);
      repeat (4) @(negedge clk);
      rd(8'h0C, d); chk("R2 idle pos", d, 3);
      wr(8'h00, 0); tick(4);
      rd(8'h0C, d); chk("R2 run off pos", d, 3);
      rd(8'h08, d); chk("R2 run off secs", d, 0);
      wr(8'h00, 1);

      // R4 fractional trim, all amounts
      for (int f = 0; f < 16; f++) begin
         mP = 1; mF = f; mOn = 1'b1;
         wr(8'h10, (32'd1 << 20) | (32'(f) << 16) | 32'd1);
         wr(8'h04, 0); model_load(0);
         sweep("R4", 2 * 16 + f + 4);
      end
      // trim amount set but disabled
      mP = 1; mF = 9; mOn = 1'b0;
      wr(8'h10, (32'd9 << 16) | 32'd1);
      wr(8'h04, 0); model_load(0);
      sweep("R4 off", 20);

      // R6 wrap and R7 second event
      wr(8'h10, 0);
      wr(8'h04, 32'hFFFF_FFFE);
      wr(8'h18, 3);
      rd(8'h18, d); chk("R9 cleared", d, 0);
      tick(1);
      rd(8'h08, d); chk("R6 to max", d, 32'hFFFF_FFFF);
      rd(8'h18, d); chk("R7 sec pending", d, 1);
      wr(8'h18, 1);
      tick(1);
      rd(8'h08, d); chk("R6 wrap", d, 0);
      rd(8'h18, d); chk("R6 pending", d & 1, 1);

      // R8 alarm
      wr(8'h14, 5);
      rd(8'h14, d); chk("R8 alarm rb", d, 5);
      wr(8'h04, 5); wr(8'h18, 3);
      rd(8'h18, d); chk("R8 load no alarm", d, 0);
      wr(8'h04, 3);
      tick(1);
      rd(8'h18, d); chk("R8 before", d & 2, 0);
      tick(1);
      rd(8'h08, d); chk("R8 secs", d, 5);
      rd(8'h18, d); chk("R8 alarm pending", d, 3);
      chk("R11 masked no irq", {30'd0, irq_alarm, irq_second}, 0);

      // R9 write 0 no effect, write 1 clears one bit
      wr(8'h18, 0);
      rd(8'h18, d); chk("R9 zero write", d, 3);
      wr(8'h18, 1);
      rd(8'h18, d); chk("R9 clear bit0", d, 2);

      // R10 / R11
      wr(8'h20, 0);
      rd(8'h1C, d); chk("R10 zero unmask", d, 3);
      wr(8'h20, 2);
      rd(8'h1C, d); chk("R10 unmask alarm", d, 1);
      chk("R11 alarm irq", {30'd0, irq_alarm, irq_second}, 2);
      wr(8'h18, 2);
      chk("R11 alarm cleared", {30'd0, irq_alarm, irq_second}, 0);
      wr(8'h20, 1);
      rd(8'h1C, d); chk("R10 unmask sec", d, 0);
      chk("R11 no pending", {30'd0, irq_alarm, irq_second}, 0);

      // R9 set wins over clear in the same cycle
      osc_tick = 1'b1;
      wr(8'h18, 1);
      osc_tick = 1'b0;
      rd(8'h18, d); chk("R9 set wins", d & 1, 1);
      chk("R11 sec irq", {30'd0, irq_alarm, irq_second}, 1);
      wr(8'h24, 0);
      rd(8'h1C, d); chk("R10 zero mask", d, 0);
      wr(8'h24, 1);
      rd(8'h1C, d); chk("R10 mask sec", d, 1);
      chk("R11 masked sec", {30'd0, irq_alarm, irq_second}, 0);

      // R12 unmapped and aliased addresses
      rd(8'h08, d);
      wr(8'h30, 32'hFFFF_FFFF);
      wr(8'h44, 32'hFFFF_FFFF);
      rd(8'h30, d); chk("R12 read hole", d, 0);
      rd(8'h48, d); chk("R12 read alias", d, 0);
      rd(8'h1C, d); chk("R12 mask kept", d, 1);
      rd(8'h10, d); chk("R12 calib kept", d, 0);
      rd(8'h00, d); chk("R12 run kept", d, 1);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule